// File: doc/BRIEF.md
# Suspend Modulation Throttle Controller

This block slows a processor core by gating it with a suspend signal. While the signal is high the core idles; while it is low the core runs. The signal alternates between a high (stall) phase and a low (run) phase. Each phase lasts a programmed number of fixed time quanta of 32 µs, so the share of full speed left to the core is run / (run + stall). The quantum comes from a prescaler on the bus clock (960 cycles at 30 MHz by default). A second prescaler gives a 1 ms unit for the hold timers.

Software sets the block up through a byte-wide register port. Two optional hold timers can lift the throttling for a while. One is retriggered by interrupt activity and the other by video activity. Each loads a reload value in milliseconds when its event arrives. While either timer is nonzero, the suspend output is held low, so the work behind the event runs at full speed. New phase lengths are taken only at a phase boundary, so a phase in progress is never cut short or stretched.

Top module: `susp_throttle`

## Requirements
- R1: After reset the suspend output is low and every register reads 0.
- R2: With modulation enabled and no hold timer active, the suspend output is high for exactly stall × TICK_DIV clocks and then low for exactly run × TICK_DIV clocks, repeating.
- R3: When bit 0 of the control register (address 0x96) is clear, the suspend output goes low by the second clock after the write and stays low.
- R4: A zero phase length skips that phase. A stall length of 0 keeps the output low, and a run length of 0 keeps it high.
- R5: Writing a new length during a phase leaves that phase's duration unchanged. The new value applies from the next phase of that kind.
- R6: The run length (0x94), stall length (0x95), control (0x96), interrupt hold reload (0x8C), video hold reload (0x8D) and hold-enable (0x80) registers read back what was written, one clock after the address is presented. Any other address reads 0.
- R7: When bit 3 of the hold-enable register is set, an interrupt event forces the suspend output low for at least (reload − 1) × MS_DIV + 1 clocks. When the bit is clear, interrupt events have no effect.
- R8: When bit 4 of the hold-enable register is set, a video event forces the output low in the same way, using the video reload. When the bit is clear, video events have no effect.
- R9: Once every hold timer has expired, at most reload × MS_DIV clocks after its last event, modulation resumes within the phase in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| irq_event | input | 1 | Interrupt activity pulse |
| video_event | input | 1 | Video activity pulse |
| suspend_out | output | 1 | Registered suspend request to the core |

## Verification
The bench measures every high and low run of the suspend output in clocks. A sequencer that is off by one quantum, or that restarts its count on a write, therefore shows up as a length mismatch. A length is rewritten in the middle of a stall phase: a design that applies it at once would shorten the current phase instead of the next one. Zero lengths are tried on each side. A design that treats zero as 256, or that stalls the sequencer, would toggle or freeze at the wrong level. Hold events are sent with their enable bit set and with it clear, and the output is then watched for resumption. A timer that ignores its enable, never expires, or misses a retrigger leaves the output at the wrong level within the windows checked.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam logic [7:0] A_RUN_LEN   = 8'h94;
  localparam logic [7:0] A_STALL_LEN = 8'h95;
  localparam logic [7:0] A_CTRL      = 8'h96;
  localparam logic [7:0] A_IRQ_HOLD  = 8'h8C;
  localparam logic [7:0] A_VID_HOLD  = 8'h8D;
  localparam logic [7:0] A_HOLD_ENA  = 8'h80;
  localparam int CTRL_MOD_BIT = 0;
  localparam int HOLD_IRQ_BIT = 3;
  localparam int HOLD_VID_BIT = 4;

  typedef struct packed {
    logic [7:0] run_len;
    logic [7:0] stall_len;
    logic [7:0] ctrl;
    logic [7:0] irq_hold;
    logic [7:0] vid_hold;
    logic [7:0] hold_ena;
  } thr_cfg_t;
endpackage

// File: rtl/thr_regs.sv
module thr_regs
  import thr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output thr_cfg_t   cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we) begin
      case (addr)
        A_RUN_LEN:   cfg.run_len   <= wdata;
        A_STALL_LEN: cfg.stall_len <= wdata;
        A_CTRL:      cfg.ctrl      <= wdata;
        A_IRQ_HOLD:  cfg.irq_hold  <= wdata;
        A_VID_HOLD:  cfg.vid_hold  <= wdata;
        A_HOLD_ENA:  cfg.hold_ena  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_RUN_LEN:   rdata <= cfg.run_len;
        A_STALL_LEN: rdata <= cfg.stall_len;
        A_CTRL:      rdata <= cfg.ctrl;
        A_IRQ_HOLD:  rdata <= cfg.irq_hold;
        A_VID_HOLD:  rdata <= cfg.vid_hold;
        A_HOLD_ENA:  rdata <= cfg.hold_ena;
        default:     rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/thr_divider.sv
module thr_divider #(
  parameter int DIV = 960
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cnt == LAST) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/thr_hold_timer.sv
module thr_hold_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ena,
  input  logic         evt,
  input  logic         ms_tick,
  input  logic [W-1:0] reload,
  output logic         active
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !ena)               cnt <= '0;
    else if (evt)                  cnt <= reload;
    else if (ms_tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/thr_duty_gen.sv
module thr_duty_gen #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [LW-1:0] stall_len,
  input  logic [LW-1:0] run_len,
  output logic          phase_on
);
  logic [LW-1:0] left;
  logic          stall_nz;
  logic          run_nz;

  assign stall_nz = (stall_len != '0);
  assign run_nz   = (run_len != '0);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase_on <= 1'b0;
      left     <= '0;
    end else if (tick) begin
      if (left > LW'(1)) begin
        left <= left - 1'b1;
      end else if (!phase_on && stall_nz) begin
        phase_on <= 1'b1;
        left     <= stall_len;
      end else if (phase_on && run_nz) begin
        phase_on <= 1'b0;
        left     <= run_len;
      end else if (stall_nz) begin
        phase_on <= 1'b1;
        left     <= stall_len;
      end else if (run_nz) begin
        phase_on <= 1'b0;
        left     <= run_len;
      end else begin
        phase_on <= 1'b0;
        left     <= '0;
      end
    end
  end
endmodule

// File: rtl/susp_throttle.sv
module susp_throttle
  import thr_pkg::*;
#(
  parameter int TICK_DIV = 960,
  parameter int MS_DIV   = 30000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       irq_event,
  input  logic       video_event,
  output logic       suspend_out
);
  localparam int NHOLD = 2;

  thr_cfg_t         cfg;
  logic             tick32;
  logic             tick_ms;
  logic             mod_en;
  logic             phase_on;
  logic             hold_any;
  logic [NHOLD-1:0] hold_act;
  logic [NHOLD-1:0] hold_ena;
  logic [NHOLD-1:0] hold_evt;
  logic [7:0]       hold_rl [NHOLD];

  thr_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
  );

  thr_divider #(.DIV(TICK_DIV)) u_qdiv (.clk(clk), .rst(rst), .tick(tick32));
  thr_divider #(.DIV(MS_DIV))   u_mdiv (.clk(clk), .rst(rst), .tick(tick_ms));

  assign mod_en      = cfg.ctrl[CTRL_MOD_BIT];
  assign hold_ena[0] = cfg.hold_ena[HOLD_IRQ_BIT];
  assign hold_ena[1] = cfg.hold_ena[HOLD_VID_BIT];
  assign hold_evt[0] = irq_event;
  assign hold_evt[1] = video_event;
  assign hold_rl[0]  = cfg.irq_hold;
  assign hold_rl[1]  = cfg.vid_hold;

  for (genvar k = 0; k < NHOLD; k++) begin : g_hold
    thr_hold_timer #(.W(8)) u_tmr (
      .clk(clk), .rst(rst), .ena(hold_ena[k]), .evt(hold_evt[k]),
      .ms_tick(tick_ms), .reload(hold_rl[k]), .active(hold_act[k])
    );
  end

  assign hold_any = |hold_act;

  thr_duty_gen #(.LW(8)) u_duty (
    .clk(clk), .rst(rst), .en(mod_en), .tick(tick32),
    .stall_len(cfg.stall_len), .run_len(cfg.run_len), .phase_on(phase_on)
  );

  always_ff @(posedge clk) begin
    if (rst) suspend_out <= 1'b0;
    else     suspend_out <= mod_en && phase_on && !hold_any;
  end
endmodule

// File: rtl/thr_checker.sv
module thr_checker #(
  parameter int TICK_DIV = 960
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic mod_en,
  input logic phase_on,
  input logic hold_any,
  input logic suspend_out
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  logic [CW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || gap == CW'(TICK_DIV - 1)) gap <= '0;
    else                                 gap <= gap + 1'b1;
  end

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap == CW'(TICK_DIV - 1)));

  assert_follow_phase_R2: assert property (@(posedge clk) disable iff (rst)
    (mod_en && phase_on && !hold_any) |=> suspend_out);

  assert_disabled_low_R3: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> !suspend_out);

  assert_no_midphase_R5: assert property (@(posedge clk) disable iff (rst)
    (mod_en && !tick) |=> $stable(phase_on));

  assert_hold_low_R7: assert property (@(posedge clk) disable iff (rst)
    hold_any |=> !suspend_out);
endmodule

bind susp_throttle thr_checker #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk(clk), .rst(rst), .tick(tick32), .mod_en(mod_en),
  .phase_on(phase_on), .hold_any(hold_any), .suspend_out(suspend_out)
);

// File: tb/sim_susp_throttle.sv
module sim_susp_throttle;
  localparam int TD = 8;
  localparam int MD = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_event = 1'b0;
  logic       video_event = 1'b0;
  logic       suspend_out;

  always #10 clk = ~clk;

  susp_throttle #(.TICK_DIV(TD), .MS_DIV(MD)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_event(irq_event),
    .video_event(video_event), .suspend_out(suspend_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int run_len = 0, last_hi = 0, last_lo = 0, n_rise = 0, n_fall = 0;
  logic prev_s = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      run_len = 0;
      prev_s  = 1'b0;
    end else begin
      if (suspend_out === prev_s) run_len++;
      else begin
        if (prev_s) begin last_hi = run_len; n_fall++; end
        else        begin last_lo = run_len; n_rise++; end
        run_len = 1;
      end
      prev_s = suspend_out;
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_fall(string req);
    int s = n_fall;
    bit ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (n_fall != s) begin ok = 1; break; end
    end
    if (!ok) chk({req, " timeout waiting fall"}, 0, 1);
  endtask

  task automatic wait_rise(string req);
    int s = n_rise;
    bit ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (n_rise != s) begin ok = 1; break; end
    end
    if (!ok) chk({req, " timeout waiting rise"}, 0, 1);
  endtask

  task automatic hold_level(string req, logic exp, int cycles);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (suspend_out !== exp) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic pulse(bit vid);
    @(negedge clk);
    if (vid) video_event = 1'b1; else irq_event = 1'b1;
    @(negedge clk);
    video_event = 1'b0; irq_event = 1'b0;
  endtask

  task automatic measure(string req, int st, int rn);
    wait_fall(req);
    wait_fall(req);
    chk({req, " stall length"}, last_hi, st * TD);
    wait_rise(req);
    chk({req, " run length"}, last_lo, rn * TD);
  endtask

  initial begin
    logic [7:0] addrs [6];
    int v;
    addrs[0] = 8'h94; addrs[1] = 8'h95; addrs[2] = 8'h96;
    addrs[3] = 8'h8C; addrs[4] = 8'h8D; addrs[5] = 8'h80;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    chk("R1 suspend after reset", suspend_out, 0);
    for (int i = 0; i < 6; i++) begin
      rd(addrs[i], v);
      chk("R1 register after reset", v, 0);
    end

    // R6: readback, random data
    for (int i = 0; i < 12; i++) begin
      int k = $urandom % 6;
      logic [7:0] d = 8'($urandom);
      wr(addrs[k], d);
      rd(addrs[k], v);
      chk("R6 readback", v, d);
    end
    rd(8'h97, v);
    chk("R6 unmapped reads zero", v, 0);
    wr(8'h80, 8'h00);
    wr(8'h96, 8'h00);

    // R2: directed and random lengths
    wr(8'h95, 8'd3); wr(8'h94, 8'd5); wr(8'h96, 8'h01);
    measure("R2 directed 3/5", 3, 5);
    wr(8'h95, 8'd1); wr(8'h94, 8'd1);
    measure("R2 directed 1/1", 1, 1);
    for (int i = 0; i < 6; i++) begin
      int st = 1 + ($urandom % 10);
      int rn = 1 + ($urandom % 10);
      wr(8'h95, 8'(st)); wr(8'h94, 8'(rn));
      measure("R2 random", st, rn);
    end

    // R5: rewrite mid-phase
    wr(8'h95, 8'd6); wr(8'h94, 8'd3);
    measure("R5 setup", 6, 3);
    wait_rise("R5");
    repeat (2 * TD) @(negedge clk);
    wr(8'h95, 8'd2);
    wait_fall("R5");
    chk("R5 phase in progress keeps old length", last_hi, 6 * TD);
    wait_fall("R5");
    chk("R5 next phase uses new length", last_hi, 2 * TD);

    // R4: zero lengths
    wr(8'h95, 8'd0); wr(8'h94, 8'd4);
    repeat (300) @(negedge clk);
    hold_level("R4 zero stall keeps output low", 1'b0, 200);
    wr(8'h95, 8'd4); wr(8'h94, 8'd0);
    repeat (300) @(negedge clk);
    hold_level("R4 zero run keeps output high", 1'b1, 200);

    // R3: disable
    wr(8'h96, 8'h00);
    @(negedge clk);
    hold_level("R3 disabled output low", 1'b0, 150);

    // R7 / R8 / R9: hold timers
    wr(8'h95, 8'd200); wr(8'h94, 8'd1);
    wr(8'h8C, 8'd2); wr(8'h8D, 8'd3);
    wr(8'h80, 8'h00); wr(8'h96, 8'h01);
    wait_rise("R7");
    repeat (3) @(negedge clk);
    pulse(1'b0);
    hold_level("R7 irq ignored when hold bit clear", 1'b1, 20);
    pulse(1'b1);
    hold_level("R8 video ignored when hold bit clear", 1'b1, 20);
    wr(8'h80, 8'h08);
    pulse(1'b1);
    hold_level("R8 video ignored with only irq bit set", 1'b1, 20);
    pulse(1'b0);
    hold_level("R7 irq hold forces low", 1'b0, 38);
    repeat (50) @(negedge clk);
    hold_level("R9 modulation resumes after irq hold", 1'b1, 20);
    wr(8'h80, 8'h10);
    pulse(1'b0);
    hold_level("R7 irq ignored with only video bit set", 1'b1, 20);
    pulse(1'b1);
    hold_level("R8 video hold forces low", 1'b0, 78);
    repeat (50) @(negedge clk);
    hold_level("R9 modulation resumes after video hold", 1'b1, 20);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule